// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the command front end of an SD card host. Software programs a 32-bit argument and then writes a 16-bit command word. If that word has its launch bit set, the block passes the command index and argument to a card-side engine through a valid/ready request. It then waits for that engine to return a response of 0, 4 or 16 bytes.

The unit checks the returned length against the response kind the command asked for. A valid response is unpacked into four 32-bit response words, with a fixed byte order. A mismatch marks the command as failed in the command word itself and sets a sticky timeout flag in a status word. A command flagged as busy-wait can raise a completion interrupt when it finishes, if that interrupt is enabled.

CRC handling, serial bit timing, clock division and timeout counting are left to the card-side engine.

Top module: `sdh_cmd_unit`

## Requirements
- R1: After reset, the command word, argument, all four response words and the status word read as zero, and `req_valid` and `busy_irq` are low.
- R2: The argument register at byte offset 0x04 reads back what was written. When a command is issued, `req_arg` carries the argument and `req_index` carries command bits 5:0.
- R3: Writing the command word (offset 0x00) with bit 15 set raises `req_valid` in the next cycle. `req_valid` stays high with a stable index and argument until `req_ready` is seen. Bit 15 reads back as 1 while the command is in flight and reads 0 once the response has been accepted.
- R4: A command write with bit 15 clear only stores the word and issues no request.
- R5: While a command is in flight, writes to the command word and to the argument are ignored.
- R6: A 4-byte response with byte k at `rsp_data[8k+7:8k]` is stored as word 0 = {b0,b1,b2,b3}, and words 1 to 3 become zero.
- R7: A 16-byte response fills word n (offset 0x10+4n) with {b(12-4n), b(13-4n), b(14-4n), b(15-4n)}, so word 3 holds the first four bytes.
- R8: When bit 10 (no response) is clear, three cases are errors: a length of 0; a length of 4 while bit 9 (long) is set; any length other than 4 or 16. On an error, command bit 14 is set, status bit 6 is set, and the response words keep their values.
- R9: When bit 10 is set, the response words keep their values and no error is flagged, whatever length is returned.
- R10: When a command with bit 11 (busy-wait) completes without error while `cfg_busy_irq_en` is high, status bit 10 is set and `busy_irq` goes high. This does not happen when the enable is low or the command failed.
- R11: Writing the status word (offset 0x20) clears each status bit that is 1 in the written data.
- R12: Reads from offsets with no register (for example 0x08 and 0x24) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cfg_busy_irq_en | input | 1 | Enables the busy-completion status |
| busy_irq | output | 1 | Busy-completion interrupt (status bit 10) |
| req_valid | output | 1 | Command request to the card engine |
| req_ready | input | 1 | Card engine accepts the request |
| req_index | output | IDX_W | Command index |
| req_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response available (one cycle) |
| rsp_len | input | LEN_W | Response length in bytes |
| rsp_data | input | 128 | Response bytes, first received in bits 7:0 |

## Verification
The bench uses the default parameters: an 8-bit offset, a 6-bit index and a 5-bit length field. The 5-bit length field can carry 0, 4, 8 and 16, which is enough to exercise every legal and illegal response length. The 8-bit offset lets the bench probe the unmapped addresses between and after the registers. A card model in the bench delays `req_ready` by a few cycles, so the request hold and the write blocking during a command are both exercised.

// File: rtl/sdh_cmd_unit.sv
`timescale 1ns/1ps
module sdh_cmd_unit #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 6,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cfg_busy_irq_en,
  output logic              busy_irq,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_index,
  output logic [31:0]       req_arg,
  input  logic              rsp_valid,
  input  logic [LEN_W-1:0]  rsp_len,
  input  logic [127:0]      rsp_data
);
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_ARG  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_RSP0 = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_RSP1 = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_RSP2 = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_RSP3 = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFS_STS  = ADDR_W'(8'h20);
  localparam int B_LONG = 9, B_NORSP = 10, B_BUSY = 11, B_FAIL = 14, B_GO = 15;
  localparam int S_TMO = 6, S_BSY = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  st_e         st_q;
  logic [15:0] cmd_q;
  logic [31:0] arg_q;
  logic [31:0] rsp_q [4];
  logic        sts_tmo_q, sts_bsy_q;
  logic [31:0] long_w [4];
  logic        in_wait, done, len_ok, rsp_bad, idle;

  function automatic logic [31:0] be_word(input logic [127:0] d, input int j);
    return {d[8*j +: 8], d[8*(j+1) +: 8], d[8*(j+2) +: 8], d[8*(j+3) +: 8]};
  endfunction

  for (genvar i = 0; i < 4; i++) begin : g_long
    assign long_w[i] = be_word(rsp_data, 12 - 4*i);
  end

  assign idle    = (st_q == ST_IDLE);
  assign in_wait = (st_q == ST_WAIT);
  assign done    = in_wait && rsp_valid;
  assign len_ok  = (rsp_len == LEN_W'(4) && !cmd_q[B_LONG]) || rsp_len == LEN_W'(16);
  assign rsp_bad = !cmd_q[B_NORSP] && !len_ok;

  assign req_valid = (st_q == ST_REQ);
  assign req_index = cmd_q[IDX_W-1:0];
  assign req_arg   = arg_q;
  assign busy_irq  = sts_bsy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cmd_q <= '0;
      arg_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (bus_we && bus_addr == OFS_CMD) begin
            cmd_q <= bus_wdata[15:0];
            if (bus_wdata[B_GO]) st_q <= ST_REQ;
          end
          if (bus_we && bus_addr == OFS_ARG) arg_q <= bus_wdata;
        end
        ST_REQ: if (req_ready) st_q <= ST_WAIT;
        default: if (rsp_valid) begin
          st_q        <= ST_IDLE;
          cmd_q[B_GO] <= 1'b0;
          if (rsp_bad) cmd_q[B_FAIL] <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) rsp_q[i] <= '0;
    end else if (done && !cmd_q[B_NORSP] && !rsp_bad) begin
      if (rsp_len == LEN_W'(4)) begin
        rsp_q[0] <= be_word(rsp_data, 0);
        for (int i = 1; i < 4; i++) rsp_q[i] <= '0;
      end else begin
        for (int i = 0; i < 4; i++) rsp_q[i] <= long_w[i];
      end
    end
  end

  logic sts_wr;
  assign sts_wr = bus_we && bus_addr == OFS_STS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_tmo_q <= 1'b0;
      sts_bsy_q <= 1'b0;
    end else begin
      sts_tmo_q <= (sts_tmo_q && !(sts_wr && bus_wdata[S_TMO])) || (done && rsp_bad);
      sts_bsy_q <= (sts_bsy_q && !(sts_wr && bus_wdata[S_BSY])) ||
                   (done && !rsp_bad && cmd_q[B_BUSY] && cfg_busy_irq_en);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CMD:  bus_rdata = {16'h0, cmd_q};
      OFS_ARG:  bus_rdata = arg_q;
      OFS_RSP0: bus_rdata = rsp_q[0];
      OFS_RSP1: bus_rdata = rsp_q[1];
      OFS_RSP2: bus_rdata = rsp_q[2];
      OFS_RSP3: bus_rdata = rsp_q[3];
      OFS_STS: begin
        bus_rdata[S_TMO] = sts_tmo_q;
        bus_rdata[S_BSY] = sts_bsy_q;
      end
      default:  bus_rdata = '0;
    endcase
  end

  logic unused_idle;
  assign unused_idle = idle;
endmodule

// File: rtl/sdh_cmd_unit_chk.sv
`timescale 1ns/1ps
module sdh_cmd_unit_chk #(
  parameter int IDX_W = 6,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IDX_W-1:0] req_index,
  input logic [31:0]      req_arg,
  input logic             rsp_valid,
  input logic [LEN_W-1:0] rsp_len,
  input logic [15:0]      cmd_q,
  input logic [31:0]      rsp_w0,
  input logic             in_wait,
  input logic             busy_irq,
  input logic             cfg_busy_irq_en
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_index) && $stable(req_arg)); // R3
  AST_REQ_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> cmd_q[15]); // R3
  AST_LAUNCH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && rsp_valid |=> !cmd_q[15]); // R3
  AST_EMPTY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && rsp_valid && !cmd_q[10] && rsp_len == '0 |=> cmd_q[14] && $stable(rsp_w0)); // R8
  AST_NORSP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && rsp_valid && cmd_q[10] |=> $stable(rsp_w0) && !$rose(cmd_q[14])); // R9
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_irq) |-> $past(in_wait && rsp_valid && cmd_q[11] && cfg_busy_irq_en)); // R10
endmodule

bind sdh_cmd_unit sdh_cmd_unit_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_index(req_index), .req_arg(req_arg), .rsp_valid(rsp_valid),
  .rsp_len(rsp_len), .cmd_q(cmd_q), .rsp_w0(rsp_q[0]), .in_wait(in_wait),
  .busy_irq(busy_irq), .cfg_busy_irq_en(cfg_busy_irq_en)
);

// File: tb/tb_sdh_cmd_unit.sv
`timescale 1ns/1ps
module tb_sdh_cmd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cfg_busy_irq_en = 1'b0;
  logic        busy_irq;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [5:0]  req_index;
  logic [31:0] req_arg;
  logic        rsp_valid = 1'b0;
  logic [4:0]  rsp_len = '0;
  logic [127:0] rsp_data = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdh_cmd_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_busy_irq_en(cfg_busy_irq_en),
    .busy_irq(busy_irq), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_arg(req_arg), .rsp_valid(rsp_valid),
    .rsp_len(rsp_len), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [127:0] pattern(input logic [7:0] base);
    logic [127:0] p;
    for (int k = 0; k < 16; k++) p[8*k +: 8] = base + 8'(k);
    return p;
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] base, input int first);
    logic [7:0] b;
    b = base + 8'(first);
    return {b, b + 8'd1, b + 8'd2, b + 8'd3};
  endfunction

  task automatic issue(input logic [15:0] cmd, input logic [4:0] len, input logic [7:0] base);
    logic [31:0] v;
    wr(8'h00, {16'h0, cmd});
    check("R3 req_valid after launch", {31'b0, req_valid}, 32'd1);
    rd(8'h00, v);
    check("R3 launch bit in flight", {31'b0, v[15]}, 32'd1);
    check("R2 req_index", {26'b0, req_index}, {26'b0, cmd[5:0]});
    repeat (2) @(negedge clk);
    check("R3 request held", {31'b0, req_valid}, 32'd1);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check("R3 request dropped after ready", {31'b0, req_valid}, 32'd0);
    rsp_valid = 1'b1; rsp_len = len; rsp_data = pattern(base);
    @(negedge clk);
    rsp_valid = 1'b0; rsp_data = '0;
    rd(8'h00, v);
    check("R3 launch bit self-clears", {31'b0, v[15]}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(8'(a * 4), v);
      check("R1 register zero after reset", v, 32'd0);
    end
    check("R1 req_valid low", {31'b0, req_valid}, 32'd0);
    check("R1 busy_irq low", {31'b0, busy_irq}, 32'd0);
  endtask

  task automatic t_arg();
    logic [31:0] v;
    wr(8'h04, 32'hA5A5_1234);
    rd(8'h04, v);
    check("R2 argument readback", v, 32'hA5A5_1234);
    wr(8'h00, 32'h0000_8411);
    check("R2 req_arg", req_arg, 32'hA5A5_1234);
    check("R2 req_index", {26'b0, req_index}, 32'h11);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_len = 5'd0;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(8'h00, 32'h0000_02C3);
    rd(8'h00, v);
    check("R4 stored without launch", v, 32'h0000_02C3);
    repeat (2) @(negedge clk);
    check("R4 no request", {31'b0, req_valid}, 32'd0);
  endtask

  task automatic t_long_then_short();
    logic [31:0] v;
    issue(16'h8202, 5'd16, 8'h40);
    for (int n = 0; n < 4; n++) begin
      rd(8'(8'h10 + 4*n), v);
      check("R7 long word order", v, exp_word(8'h40, 12 - 4*n));
    end
    issue(16'h8011, 5'd4, 8'h10);
    rd(8'h10, v);
    check("R6 short word 0", v, 32'h1011_1213);
    for (int n = 1; n < 4; n++) begin
      rd(8'(8'h10 + 4*n), v);
      check("R6 upper words cleared", v, 32'd0);
    end
    rd(8'h00, v);
    check("R6 command word after success", v, 32'h0000_0011);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    issue(16'h8005, 5'd0, 8'h70);
    rd(8'h00, v);
    check("R8 fail bit on empty response", v, 32'h0000_4005);
    rd(8'h20, v);
    check("R8 timeout status", v, 32'h0000_0040);
    rd(8'h10, v);
    check("R8 response kept", v, 32'h1011_1213);
    wr(8'h20, 32'h0000_0040);
    rd(8'h20, v);
    check("R11 status cleared", v, 32'd0);
    issue(16'h8206, 5'd4, 8'h80);
    rd(8'h00, v);
    check("R8 fail on short for long", v, 32'h0000_4206);
    rd(8'h10, v);
    check("R8 response kept", v, 32'h1011_1213);
    wr(8'h20, 32'h0000_0040);
    issue(16'h8007, 5'd8, 8'h90);
    rd(8'h00, v);
    check("R8 fail on length 8", v, 32'h0000_4007);
    rd(8'h20, v);
    check("R8 timeout status", v, 32'h0000_0040);
    wr(8'h20, 32'h0000_0040);
  endtask

  task automatic t_norsp();
    logic [31:0] v;
    issue(16'h8400, 5'd0, 8'hA0);
    rd(8'h00, v);
    check("R9 no fail", v, 32'h0000_0400);
    rd(8'h20, v);
    check("R9 no status", v, 32'd0);
    issue(16'h8401, 5'd16, 8'hB0);
    rd(8'h10, v);
    check("R9 response kept", v, 32'h1011_1213);
    rd(8'h1C, v);
    check("R9 response word 3 kept", v, 32'd0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    cfg_busy_irq_en = 1'b0;
    issue(16'h8807, 5'd4, 8'h20);
    rd(8'h20, v);
    check("R10 no busy status when disabled", v, 32'd0);
    cfg_busy_irq_en = 1'b1;
    issue(16'h8807, 5'd4, 8'h20);
    rd(8'h20, v);
    check("R10 busy status", v, 32'h0000_0400);
    check("R10 busy_irq high", {31'b0, busy_irq}, 32'd1);
    wr(8'h20, 32'h0000_0040);
    check("R11 other bit kept", {31'b0, busy_irq}, 32'd1);
    wr(8'h20, 32'h0000_0400);
    check("R11 busy_irq cleared", {31'b0, busy_irq}, 32'd0);
    issue(16'h8807, 5'd0, 8'h20);
    rd(8'h20, v);
    check("R10 no busy on error", v, 32'h0000_0040);
    check("R10 busy_irq low on error", {31'b0, busy_irq}, 32'd0);
    wr(8'h20, 32'hFFFF_FFFF);
    cfg_busy_irq_en = 1'b0;
  endtask

  task automatic t_inflight();
    logic [31:0] v;
    wr(8'h04, 32'h1357_9BDF);
    wr(8'h00, 32'h0000_8003);
    wr(8'h00, 32'h0000_0009);
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h00, v);
    check("R5 command write ignored", v, 32'h0000_8003);
    rd(8'h04, v);
    check("R5 argument write ignored", v, 32'h1357_9BDF);
    check("R5 req_arg stable", req_arg, 32'h1357_9BDF);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_len = 5'd4; rsp_data = pattern(8'hC0);
    @(negedge clk);
    rsp_valid = 1'b0;
    rd(8'h10, v);
    check("R5 command completes", v, 32'hC0C1_C2C3);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'h08, v);
    check("R12 unmapped 0x08", v, 32'd0);
    rd(8'h24, v);
    check("R12 unmapped 0x24", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arg();
    t_plain();
    t_long_then_short();
    t_errors();
    t_norsp();
    t_busy();
    t_inflight();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule